// File: doc/BRIEF.md
# SDRAM Mode Register and Read Latency Unit

This block is the device-side control logic of a mobile SDRAM. It decodes register-set commands from the command and address bus. A command with bank address 00 writes the base register, which holds the burst length, the burst ordering, the read latency and the write-burst policy. A command with bank address 10 writes the extended register, which holds the partial-array self-refresh region code and the temperature range code. A setting is stored only when it is legal. Every refused setting raises a one-cycle flag.

For each accepted READ the block generates the column sequence of the burst. Each read beat comes out after the programmed latency of 2 or 3 cycles. A simple pattern derived from the column address stands in for the data array. Each accepted WRITE produces its column sequence with no latency. A write uses either the programmed burst length or, when the write-single policy is set, one beat.

After a register-set command, commands stay blocked for `MRD_WAIT` cycles (at least 2). The block runs one burst at a time. Commands that arrive while it is blocked or busy are flagged and dropped.

Top module: `sdram_mode_ctl`

## Requirements
- R1: After reset, the stored settings are: burst code 011 (8 beats), sequential ordering, latency 2, write bursts at full length, region code 000 and temperature code 00. Both error flags and both valid strobes are low.
- R2: A register-set command (cmd_op 2) with cmd_ba 00 stores its fields when they are legal, and the new values appear after that clock edge. The fields are: A2..A0 burst code (000, 001, 010, 011 and 111 give 1, 2, 4, 8 and 2^COL_W beats), A3 ordering (1 = interleaved), A6..A4 latency, and A9 write-single.
- R3: A base register-set command with burst code 100, 101 or 110, or with a latency field other than 2 or 3, pulses illegal_err for one cycle and leaves every stored setting unchanged.
- R4: A register-set command with cmd_ba 10 stores A2..A0 as the region code and A4..A3 as the temperature code. It is refused with an illegal_err pulse, and nothing changes, in any of these cases: region code 011, 100 or 111; temperature code 11; any nonzero bit in A12..A5; or a register-set command with cmd_ba 01 or 11.
- R5: A register-set command while banks_idle is low pulses proto_err and changes no setting.
- R6: After a register-set command that passes the idle check, the next MRD_WAIT command edges are refused with proto_err. The following command is accepted.
- R7: A READ (cmd_op 0) accepted on edge n puts beat k on rd_valid/rd_col after edge n+L+k, where L is the stored latency. rd_valid is high for exactly the burst length.
- R8: With sequential ordering, beat k keeps the start column's bits above log2(length). Its low bits are (start + k) mod length.
- R9: With interleaved ordering, the low log2(length) bits of beat k are the start column's low bits XOR k.
- R10: rd_data equals {rd_col XOR DATA_SALT, rd_col}, with DATA_SALT defaulting to 8'hA5.
- R11: A WRITE (cmd_op 1) accepted on edge n puts beat k on wr_valid/wr_col after edge n+1+k, using the R8/R9 ordering. When write-single is set, the write is one beat at the start column.
- R12: Any command that arrives while a burst is in flight is refused with proto_err and has no effect. A read burst is in flight until edge n+len+2 and a write burst until edge n+len.
- R13: A refused command (busy, or not idle) raises only proto_err and never illegal_err, even when its fields are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 0 read, 1 write, 2 register set, 3 other |
| cmd_ba | input | 2 | Bank address, selects the register for a set |
| cmd_addr | input | ADDR_W | Address bus: column for read/write, fields for a set |
| banks_idle | input | 1 | All banks idle (from array state) |
| rd_valid | output | 1 | Read beat valid |
| rd_col | output | COL_W | Column of the read beat |
| rd_data | output | 2*COL_W | Pattern data of the read beat |
| wr_valid | output | 1 | Write beat valid |
| wr_col | output | COL_W | Column of the write beat |
| proto_err | output | 1 | Command refused for timing or idle rules |
| illegal_err | output | 1 | Register-set refused for illegal field values |
| cfg_burst_code | output | 3 | Stored burst length code |
| cfg_interleave | output | 1 | Stored ordering |
| cfg_latency | output | 2 | Stored read latency |
| cfg_wr_single | output | 1 | Stored write-single policy |
| cfg_pasr | output | 3 | Stored self-refresh region code |
| cfg_tcsr | output | 2 | Stored temperature code |

## Verification
The case that matters most is a register-set command arriving while read beats are still in the latency pipeline. That command might change the latency under beats already in flight. The bench injects a latency-changing set one cycle after a READ, and again just as the engine has finished but the pipeline still holds the last beat. It then checks that proto_err pulses, that the stored latency holds, and that every beat still lands on the old latency. A second overlap is an illegal setting combined with a non-idle array. The bench checks that only the protocol flag rises.

// File: rtl/sdmr_pkg.sv
package sdmr_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_OTHER = 2'd3
  } op_e;

  typedef struct packed {
    logic [2:0] bl;
    logic       ilv;
    logic [1:0] cl;
    logic       wr_one;
    logic [2:0] pasr;
    logic [1:0] tcsr;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{bl: 3'b011, ilv: 1'b0, cl: 2'd2, wr_one: 1'b0,
                                 pasr: 3'b000, tcsr: 2'b00};

  function automatic logic bl_code_ok(input logic [2:0] c);
    return (c <= 3'd3) || (c == 3'd7);
  endfunction

  function automatic logic pasr_code_ok(input logic [2:0] c);
    return !((c == 3'd3) || (c == 3'd4) || (c == 3'd7));
  endfunction

endpackage

// File: rtl/sdmr_regs.sv
module sdmr_regs
  import sdmr_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int MRD_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_go,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output cfg_t              cfg,
  output logic              illegal,
  output logic              wait_busy
);
  localparam int CNT_W = $clog2(MRD_WAIT + 1);

  logic [CNT_W-1:0] cnt;
  logic             base_ok, ext_ok;

  always_comb begin
    base_ok = bl_code_ok(addr[2:0]) && (addr[6:4] == 3'd2 || addr[6:4] == 3'd3);
    ext_ok  = pasr_code_ok(addr[2:0]) && (addr[4:3] != 2'b11) && (addr[ADDR_W-1:5] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= CFG_RESET;
      illegal <= 1'b0;
      cnt     <= '0;
    end else begin
      illegal <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (set_go) begin
        cnt <= CNT_W'(MRD_WAIT);
        case (ba)
          2'b00: begin
            if (base_ok) begin
              cfg.bl     <= addr[2:0];
              cfg.ilv    <= addr[3];
              cfg.cl     <= addr[5:4];
              cfg.wr_one <= addr[9];
            end else begin
              illegal <= 1'b1;
            end
          end
          2'b10: begin
            if (ext_ok) begin
              cfg.pasr <= addr[2:0];
              cfg.tcsr <= addr[4:3];
            end else begin
              illegal <= 1'b1;
            end
          end
          default: illegal <= 1'b1;
        endcase
      end
    end
  end

  assign wait_busy = (cnt != '0);

endmodule

// File: rtl/sdmr_burst.sv
module sdmr_burst #(
  parameter int COL_W = 8,
  parameter int LGW   = $clog2(COL_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic [LGW-1:0]   len_lg,
  input  logic             ilv,
  output logic             beat_v,
  output logic             beat_wr,
  output logic [COL_W-1:0] beat_col
);
  logic             active, wr_q, ilv_q;
  logic [LGW-1:0]   lg_q;
  logic [COL_W-1:0] base_q, idx, mask, low;
  logic [COL_W:0]   span;

  always_comb begin
    span     = ({{COL_W{1'b0}}, 1'b1} << lg_q) - 1'b1;
    mask     = span[COL_W-1:0];
    low      = ilv_q ? (base_q ^ idx) : (base_q + idx);
    beat_col = (base_q & ~mask) | (low & mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      wr_q   <= 1'b0;
      ilv_q  <= 1'b0;
      lg_q   <= '0;
      base_q <= '0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      wr_q   <= start_wr;
      ilv_q  <= ilv;
      lg_q   <= len_lg;
      base_q <= start_col;
      idx    <= '0;
    end else if (active) begin
      if (idx == mask) active <= 1'b0;
      else             idx    <= idx + 1'b1;
    end
  end

  assign beat_v  = active;
  assign beat_wr = wr_q;

endmodule

// File: rtl/sdmr_rdpipe.sv
module sdmr_rdpipe #(
  parameter int               COL_W  = 8,
  parameter logic [COL_W-1:0] SALT   = 8'hA5,
  parameter int               STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_v,
  input  logic [COL_W-1:0]   in_col,
  input  logic               long_lat,
  output logic               out_v,
  output logic [COL_W-1:0]   out_col,
  output logic [2*COL_W-1:0] out_data,
  output logic               pending
);
  logic [STAGES-1:0] st_v;
  logic [COL_W-1:0]  st_c [STAGES];
  logic              pick_v;
  logic [COL_W-1:0]  pick_c;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        st_v[g] <= 1'b0;
        st_c[g] <= '0;
      end else if (g == 0) begin
        st_v[g] <= in_v;
        st_c[g] <= in_col;
      end else begin
        st_v[g] <= st_v[(g == 0) ? 0 : g-1];
        st_c[g] <= st_c[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_comb begin
    pick_v = long_lat ? st_v[STAGES-1] : st_v[0];
    pick_c = long_lat ? st_c[STAGES-1] : st_c[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v    <= 1'b0;
      out_col  <= '0;
      out_data <= '0;
    end else begin
      out_v    <= pick_v;
      out_col  <= pick_c;
      out_data <= {pick_c ^ SALT, pick_c};
    end
  end

  assign pending = |st_v;

endmodule

// File: rtl/sdram_mode_ctl.sv
module sdram_mode_ctl
  import sdmr_pkg::*;
#(
  parameter int               ADDR_W    = 13,
  parameter int               COL_W     = 8,
  parameter int               MRD_WAIT  = 2,
  parameter logic [COL_W-1:0] DATA_SALT = 8'hA5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [1:0]         cmd_ba,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic               banks_idle,
  output logic               rd_valid,
  output logic [COL_W-1:0]   rd_col,
  output logic [2*COL_W-1:0] rd_data,
  output logic               wr_valid,
  output logic [COL_W-1:0]   wr_col,
  output logic               proto_err,
  output logic               illegal_err,
  output logic [2:0]         cfg_burst_code,
  output logic               cfg_interleave,
  output logic [1:0]         cfg_latency,
  output logic               cfg_wr_single,
  output logic [2:0]         cfg_pasr,
  output logic [1:0]         cfg_tcsr
);
  localparam int LGW        = $clog2(COL_W + 1);
  localparam int MIN_LAT    = 2;
  localparam int MAX_LAT    = 3;
  localparam int PIPE_DEPTH = MAX_LAT - MIN_LAT + 1;

  op_e              op;
  cfg_t             cfg;
  logic             wait_busy, pipe_pending, busy, accept;
  logic             set_go, rd_go, wr_go, proto_d;
  logic             beat_v, beat_wr;
  logic [COL_W-1:0] beat_col;
  logic [LGW-1:0]   len_lg;

  assign op      = op_e'(cmd_op);
  assign busy    = wait_busy | beat_v | pipe_pending;
  assign accept  = cmd_valid & ~busy;
  assign set_go  = accept & (op == OP_SET) & banks_idle;
  assign rd_go   = accept & (op == OP_READ);
  assign wr_go   = accept & (op == OP_WRITE);
  assign proto_d = cmd_valid & (busy | ((op == OP_SET) & ~banks_idle));

  always_comb begin
    if (wr_go && cfg.wr_one)  len_lg = '0;
    else if (cfg.bl == 3'd7)  len_lg = LGW'(COL_W);
    else                      len_lg = LGW'(cfg.bl[1:0]);
  end

  sdmr_regs #(.ADDR_W(ADDR_W), .MRD_WAIT(MRD_WAIT)) u_regs (
    .clk(clk), .rst(rst), .set_go(set_go), .ba(cmd_ba), .addr(cmd_addr),
    .cfg(cfg), .illegal(illegal_err), .wait_busy(wait_busy)
  );

  sdmr_burst #(.COL_W(COL_W), .LGW(LGW)) u_burst (
    .clk(clk), .rst(rst), .start(rd_go | wr_go), .start_wr(wr_go),
    .start_col(cmd_addr[COL_W-1:0]), .len_lg(len_lg), .ilv(cfg.ilv),
    .beat_v(beat_v), .beat_wr(beat_wr), .beat_col(beat_col)
  );

  sdmr_rdpipe #(.COL_W(COL_W), .SALT(DATA_SALT), .STAGES(PIPE_DEPTH)) u_pipe (
    .clk(clk), .rst(rst), .in_v(beat_v & ~beat_wr), .in_col(beat_col),
    .long_lat(cfg.cl == 2'(MAX_LAT)), .out_v(rd_valid), .out_col(rd_col),
    .out_data(rd_data), .pending(pipe_pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid  <= 1'b0;
      wr_col    <= '0;
      proto_err <= 1'b0;
    end else begin
      wr_valid  <= beat_v & beat_wr;
      wr_col    <= beat_col;
      proto_err <= proto_d;
    end
  end

  assign cfg_burst_code = cfg.bl;
  assign cfg_interleave = cfg.ilv;
  assign cfg_latency    = cfg.cl;
  assign cfg_wr_single  = cfg.wr_one;
  assign cfg_pasr       = cfg.pasr;
  assign cfg_tcsr       = cfg.tcsr;

endmodule

// File: rtl/sdmr_checker.sv
module sdmr_checker (
  input logic       clk,
  input logic       rst,
  input logic       proto_err,
  input logic       illegal_err,
  input logic       rd_valid,
  input logic       wr_valid,
  input logic [2:0] cfg_burst_code,
  input logic       cfg_interleave,
  input logic [1:0] cfg_latency,
  input logic       cfg_wr_single,
  input logic [2:0] cfg_pasr,
  input logic [1:0] cfg_tcsr
);
  logic [11:0] cfg_all;
  assign cfg_all = {cfg_burst_code, cfg_interleave, cfg_latency, cfg_wr_single, cfg_pasr, cfg_tcsr};

  AST_LAT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cfg_latency == 2'd2) || (cfg_latency == 2'd3)); // R3
  AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cfg_pasr != 3'd3) && (cfg_pasr != 3'd4) && (cfg_pasr != 3'd7) && (cfg_tcsr != 2'b11)); // R4
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    illegal_err |-> $stable(cfg_all)); // R3
  AST_PROTO_HOLDS: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $stable(cfg_all)); // R5
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(proto_err && illegal_err)); // R13
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_valid)); // R12
endmodule

bind sdram_mode_ctl sdmr_checker u_chk (
  .clk(clk), .rst(rst), .proto_err(proto_err), .illegal_err(illegal_err),
  .rd_valid(rd_valid), .wr_valid(wr_valid), .cfg_burst_code(cfg_burst_code),
  .cfg_interleave(cfg_interleave), .cfg_latency(cfg_latency),
  .cfg_wr_single(cfg_wr_single), .cfg_pasr(cfg_pasr), .cfg_tcsr(cfg_tcsr)
);

// File: tb/tb_sdram_mode_ctl.sv
module tb_sdram_mode_ctl;
  localparam int W = 2;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cmd_valid = 1'b0, banks_idle = 1'b1;
  logic [1:0]  cmd_op = '0, cmd_ba = '0;
  logic [12:0] cmd_addr = '0;
  logic        rd_valid, wr_valid, proto_err, illegal_err;
  logic [7:0]  rd_col, wr_col;
  logic [15:0] rd_data;
  logic [2:0]  cfg_burst_code, cfg_pasr;
  logic        cfg_interleave, cfg_wr_single;
  logic [1:0]  cfg_latency, cfg_tcsr;

  int nchk = 0, nfail = 0;
  logic [2:0] m_bl = 3'b011, m_pasr = 3'b000;
  logic       m_ilv = 1'b0, m_wr1 = 1'b0;
  logic [1:0] m_cl = 2'd2, m_tcsr = 2'b00;

  always #10 clk = ~clk;

  sdram_mode_ctl #(.MRD_WAIT(W)) dut (.*);

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int blen(input logic [2:0] c);
    return (c == 3'd7) ? 256 : (1 << c);
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int k, input int len, input logic il);
    logic [7:0] msk, lo;
    msk = 8'(len - 1);
    lo  = il ? (s ^ 8'(k)) : (s + 8'(k));
    return (s & ~msk) | (lo & msk);
  endfunction

  task automatic check_cfg(input string tag);
    logic [11:0] a, e;
    a = {cfg_burst_code, cfg_interleave, cfg_latency, cfg_wr_single, cfg_pasr, cfg_tcsr};
    e = {m_bl, m_ilv, m_cl, m_wr1, m_pasr, m_tcsr};
    check(a == e, tag, 32'(a), 32'(e));
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] b, input logic [12:0] a,
                       input logic idle, output logic pe, output logic ie);
    cmd_valid = 1'b1; cmd_op = op; cmd_ba = b; cmd_addr = a; banks_idle = idle;
    @(negedge clk);
    pe = proto_err; ie = illegal_err;
    cmd_valid = 1'b0; banks_idle = 1'b1;
  endtask

  task automatic do_set(input logic [1:0] b, input logic [12:0] a, input logic idle,
                        input logic wait_after, input string tag);
    logic pe, ie, ok;
    issue(2'd2, b, a, idle, pe, ie);
    ok = 1'b0;
    if (idle) begin
      if (b == 2'b00) begin
        ok = (a[2:0] <= 3'd3 || a[2:0] == 3'd7) && (a[6:4] == 3'd2 || a[6:4] == 3'd3);
        if (ok) begin m_bl = a[2:0]; m_ilv = a[3]; m_cl = a[5:4]; m_wr1 = a[9]; end
      end else if (b == 2'b10) begin
        ok = !(a[2:0] == 3'd3 || a[2:0] == 3'd4 || a[2:0] == 3'd7) && a[4:3] != 2'b11 && a[12:5] == '0;
        if (ok) begin m_pasr = a[2:0]; m_tcsr = a[4:3]; end
      end
    end
    check(pe == !idle, {tag, " proto_err"}, 32'(pe), 32'(!idle));
    check(ie == (idle && !ok), {tag, " illegal_err"}, 32'(ie), 32'(idle && !ok));
    check_cfg({tag, " cfg"});
    if (wait_after) repeat (W) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] col, input int inj_t, input string tag);
    logic pe, ie;
    int len, lat;
    len = blen(m_bl); lat = int'(m_cl);
    issue(2'd0, 2'b00, {5'd0, col}, 1'b1, pe, ie);
    check(!pe && !rd_valid, {tag, " R7 accept"}, 32'(pe), 0);
    for (int t = 1; t <= lat + len + 1; t++) begin
      if (t == inj_t) begin
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_ba = 2'b00; cmd_addr = 13'h033;
      end
      @(negedge clk);
      if (t == inj_t) begin
        cmd_valid = 1'b0;
        check(proto_err && !illegal_err, {tag, " R12 R13 set during burst"}, 32'({proto_err, illegal_err}), 32'b10);
        check_cfg({tag, " R12 cfg kept"});
      end
      if (t >= lat && t < lat + len) begin
        logic [7:0] ec;
        ec = exp_col(col, t - lat, len, m_ilv);
        check(rd_valid && rd_col == ec, {tag, m_ilv ? " R7 R9 rd beat" : " R7 R8 rd beat"},
              32'({rd_valid, rd_col}), 32'({1'b1, ec}));
        check(rd_data == {ec ^ 8'hA5, ec}, {tag, " R10 rd_data"}, 32'(rd_data), 32'({ec ^ 8'hA5, ec}));
      end else begin
        check(!rd_valid, {tag, " R7 rd idle"}, 32'(rd_valid), 0);
      end
    end
  endtask

  task automatic do_write(input logic [7:0] col, input string tag);
    logic pe, ie;
    int len;
    len = m_wr1 ? 1 : blen(m_bl);
    issue(2'd1, 2'b00, {5'd0, col}, 1'b1, pe, ie);
    check(!pe && !wr_valid, {tag, " R11 accept"}, 32'(pe), 0);
    for (int t = 1; t <= len + 1; t++) begin
      @(negedge clk);
      if (t <= len) begin
        logic [7:0] ec;
        ec = exp_col(col, t - 1, len, m_ilv);
        check(wr_valid && wr_col == ec, {tag, " R11 wr beat"}, 32'({wr_valid, wr_col}), 32'({1'b1, ec}));
      end else begin
        check(!wr_valid, {tag, " R11 wr end"}, 32'(wr_valid), 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic pe, ie;
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_cfg("R1 reset cfg");
    check({proto_err, illegal_err, rd_valid, wr_valid} == 4'b0, "R1 reset flags",
          32'({proto_err, illegal_err, rd_valid, wr_valid}), 0);

    do_set(2'b00, 13'h031, 1'b1, 1'b1, "R2 bl2 seq lat3");
    do_read(8'h17, 0, "R8 seq2");
    do_set(2'b00, 13'h02B, 1'b1, 1'b1, "R2 bl8 ilv lat2");
    do_read(8'h35, 0, "R9 ilv8");
    do_write(8'h3C, "R11 burst");
    do_set(2'b00, 13'h22B, 1'b1, 1'b1, "R2 wr single");
    do_write(8'h3C, "R11 single");
    do_set(2'b00, 13'h027, 1'b1, 1'b1, "R2 full page");
    do_read(8'hFE, 0, "R8 page wrap");
    do_set(2'b00, 13'h025, 1'b1, 1'b1, "R3 bl code 101");
    do_set(2'b00, 13'h043, 1'b1, 1'b1, "R3 lat 4");
    do_set(2'b00, 13'h013, 1'b1, 1'b1, "R3 lat 1");
    do_set(2'b10, 13'h00D, 1'b1, 1'b1, "R4 ext legal");
    do_set(2'b10, 13'h003, 1'b1, 1'b1, "R4 pasr 011");
    do_set(2'b10, 13'h018, 1'b1, 1'b1, "R4 tcsr 11");
    do_set(2'b10, 13'h020, 1'b1, 1'b1, "R4 high bit");
    do_set(2'b01, 13'h031, 1'b1, 1'b1, "R4 wrong bank");
    do_set(2'b00, 13'h030, 1'b0, 1'b1, "R5 not idle");
    do_set(2'b10, 13'h1FF, 1'b0, 1'b1, "R13 illegal and not idle");

    do_set(2'b00, 13'h032, 1'b1, 1'b0, "R6 set");
    for (int i = 0; i < W; i++) begin
      issue(2'd0, 2'b00, 13'h004, 1'b1, pe, ie);
      check(pe && !ie, "R6 refused in wait", 32'({pe, ie}), 32'b10);
    end
    do_read(8'h04, 0, "R6 accepted after wait");

    do_set(2'b00, 13'h020, 1'b1, 1'b1, "R12 bl1 lat2");
    do_read(8'h09, 2, "R12 pipe drain");
    do_set(2'b00, 13'h022, 1'b1, 1'b1, "R12 bl4 lat2");
    do_read(8'h41, 1, "R12 engine busy");

    r = $urandom(32'd2024);
    for (int i = 0; i < 30; i++) begin
      logic [12:0] a;
      a = 13'($urandom);
      a[12:10] = '0; a[8:7] = '0;
      if ($urandom % 4 != 0) a[6:4] = ($urandom % 2 == 0) ? 3'd2 : 3'd3;
      do_set(2'b00, a, ($urandom % 8) != 0, 1'b1, "R2 R3 random base");
      a = 13'($urandom % 32);
      if ($urandom % 5 == 0) a[7] = 1'b1;
      do_set(2'b10, a, 1'b1, 1'b1, "R4 random ext");
      do_read(8'($urandom), 0, "R7 random read");
      do_write(8'($urandom), "R11 random write");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule